// File: doc/BRIEF.md
# Global Exclusive Reservation Monitor

This block arbitrates exclusive load/store pairs across several processors that share memory. It keeps one reservation slot for each processor. Each slot is either open or held, and a held slot records the address region that its processor loaded exclusively. The block moves no data. It sees the request stream, updates the slots, and answers each exclusive store with a grant or a deny. A granted exclusive store is the only kind that the memory system should let commit.

Requests arrive on a single port, at most one per cycle. Each request carries the originating processor's index, an operation code and a byte address. Addresses are compared at region granularity: the low 11 address bits are ignored. A store from any processor kills matching reservations held by the other processors. A per-processor counter forces an exclusive store to fail once every few attempts, so that software retry loops still get exercised when no contention exists. A separate port retires a processor's slot, for example when that processor leaves the coherence domain.

Top module: `excl_monitor_global`

## Requirements
- R1: After a synchronous active-low reset, every slot is open, every failure counter is zero, and `stex_done`/`stex_ok` are 0.
- R2: Two addresses match when they agree in every bit above bit 10. Bits 10..0 never affect a match.
- R3: An exclusive load (op 2'b01) from processor P makes P's slot held and records the request's region, replacing any earlier region.
- R4: An exclusive store (op 2'b11) from P raises `stex_done` in the following cycle. `stex_ok` is 1 in that cycle only if P's slot was held for the same region and no forced failure was due.
- R5: Any exclusive store from P leaves P's slot open, whether granted or denied, so a second exclusive store without a new exclusive load is denied.
- R6: A plain store (op 2'b10) from P opens every other processor's held slot in the same region. P's own slot is unaffected.
- R7: A granted exclusive store from P opens every other processor's held slot in the same region. A denied one leaves the other slots unchanged.
- R8: Each processor counts its exclusive stores whose slot was held for a matching region. The first five such stores are granted. The next one is denied and restarts the count at zero. Non-matching exclusive stores do not count.
- R9: A drop request (`drop_valid` with `drop_id`) opens that processor's slot and zeroes its failure counter. If a request from the same processor arrives in the same cycle, the drop wins for that slot's state.
- R10: A plain load (op 2'b00), or any cycle with `req_valid` low, changes no slot and produces no `stex_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 00 load, 01 exclusive load, 10 store, 11 exclusive store |
| req_id | input | ID_W (2) | Index of the requesting processor |
| req_addr | input | ADDR_W (32) | Byte address of the request |
| drop_valid | input | 1 | Retire one processor's slot |
| drop_id | input | ID_W (2) | Index of the slot to retire |
| stex_done | output | 1 | An exclusive store was resolved in the previous cycle |
| stex_ok | output | 1 | That exclusive store was granted |

## Verification
The bench runs directed sequences first. These include a load/store pair within one region and a pair that crosses a region boundary, which separates correct masking from a wrong mask width. A foreign store and an own store are compared against each other, so a bench run can tell apart the killing of other slots and the sparing of the requester's own slot. Two processors that both reserve one region show that a grant spreads the kill and a deny does not. A long run on one processor exposes the period of the forced failure. A random phase then mixes all operations, drops and idle cycles over a few regions. It is compared every cycle with a behavioural model, which catches ordering errors, such as a drop colliding with a request in the same cycle.

// File: rtl/xmon_pkg.sv
// Package: shared operation and slot-state encodings for the exclusive monitor.
// Assumes a 2-bit operation field on the request port.
package xmon_pkg;
    typedef enum logic [1:0] {
        XOP_LOAD  = 2'b00,
        XOP_LDEX  = 2'b01,
        XOP_STORE = 2'b10,
        XOP_STEX  = 2'b11
    } xmon_op_e;

    typedef enum logic {
        RSV_OPEN = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_e;
endpackage

// File: rtl/xmon_slot.sv
// Module: one processor's reservation slot with its forced-failure counter.
// Assumes the address it receives is already masked to region granularity,
// and that at most one request and one drop are presented per cycle.
module xmon_slot
    import xmon_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int FAIL_PERIOD = 5,
    parameter int CNT_W       = $clog2(FAIL_PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_live,
    input  xmon_op_e          req_op,
    input  logic              req_self,
    input  logic [ADDR_W-1:0] req_region,
    input  logic              grant_bcast,
    input  logic              drop_me,
    output logic              hit,
    output logic              fail_due
);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(FAIL_PERIOD);

    rsv_state_e        state_q;
    logic [ADDR_W-1:0] region_q;
    logic [CNT_W-1:0]  cnt_q;

    // Match and failure-due flags seen by the resolver.
    always_comb begin
        hit      = (state_q == RSV_HELD) && (region_q == req_region);
        fail_due = (cnt_q == CNT_LIMIT);
    end

    // Slot state update: drop first, otherwise react to the live request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RSV_OPEN;
            region_q <= '0;
            cnt_q    <= '0;
        end else if (drop_me) begin
            state_q <= RSV_OPEN;
            cnt_q   <= '0;
        end else if (req_live) begin
            unique case (req_op)
                XOP_LDEX: begin
                    if (req_self) begin
                        state_q  <= RSV_HELD;
                        region_q <= req_region;
                    end
                end
                XOP_STORE: begin
                    if (!req_self && hit) state_q <= RSV_OPEN;
                end
                XOP_STEX: begin
                    if (req_self) begin
                        state_q <= RSV_OPEN;
                        if (hit) cnt_q <= fail_due ? '0 : cnt_q + CNT_W'(1);
                    end else if (grant_bcast && hit) begin
                        state_q <= RSV_OPEN;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3
    ldex_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_live && req_self && req_op == XOP_LDEX && !drop_me)
        |=> (state_q == RSV_HELD && region_q == $past(req_region)));

    // R5
    stex_opens_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_live && req_self && req_op == XOP_STEX) |=> (state_q == RSV_OPEN));

    // R6
    foreign_store_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_live && !req_self && req_op == XOP_STORE && hit) |=> (state_q == RSV_OPEN));

    // R9
    drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_me |=> (state_q == RSV_OPEN && cnt_q == '0));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LIMIT);
endmodule

// File: rtl/xmon_resolve.sv
// Module: decides whether the current exclusive store is granted.
// Assumes the requester index has already been range-checked by the caller.
module xmon_resolve #(
    parameter int NPROC = 4,
    parameter int ID_W  = $clog2(NPROC)
) (
    input  logic [NPROC-1:0] hit_vec,
    input  logic [NPROC-1:0] due_vec,
    input  logic [ID_W-1:0]  req_id,
    input  logic             stex_live,
    output logic             grant
);
    // Grant needs the requester's live reservation and no pending forced failure.
    always_comb begin
        grant = stex_live && hit_vec[req_id] && !due_vec[req_id];
    end
endmodule

// File: rtl/excl_monitor_global.sv
// Module: global exclusive monitor with one reservation slot per processor.
// Takes one request per cycle and answers each exclusive store one cycle
// later. It tracks state only; memory accesses are done elsewhere.
module excl_monitor_global
    import xmon_pkg::*;
#(
    parameter int NPROC       = 4,
    parameter int ADDR_W      = 32,
    parameter int REGION_LSB  = 11,
    parameter int FAIL_PERIOD = 5,
    parameter int ID_W        = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              drop_valid,
    input  logic [ID_W-1:0]   drop_id,
    output logic              stex_done,
    output logic              stex_ok
);
    localparam logic [ADDR_W-1:0] REGION_MASK = ~((ADDR_W'(1) << REGION_LSB) - ADDR_W'(1));
    localparam logic [ID_W:0]     NPROC_W     = (ID_W + 1)'(NPROC);

    xmon_op_e          op;
    logic              id_ok;
    logic              req_live;
    logic              stex_live;
    logic              grant;
    logic [ADDR_W-1:0] region;
    logic [NPROC-1:0]  hit_vec;
    logic [NPROC-1:0]  due_vec;

    // Decode the request into region, operation and liveness.
    always_comb begin
        op        = xmon_op_e'(req_op);
        id_ok     = ({1'b0, req_id} < NPROC_W);
        req_live  = req_valid && id_ok;
        stex_live = req_live && (op == XOP_STEX);
        region    = req_addr & REGION_MASK;
    end

    for (genvar i = 0; i < NPROC; i++) begin : g_slot
        xmon_slot #(
            .ADDR_W      (ADDR_W),
            .FAIL_PERIOD (FAIL_PERIOD)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_live    (req_live),
            .req_op      (op),
            .req_self    (req_id == ID_W'(i)),
            .req_region  (region),
            .grant_bcast (grant),
            .drop_me     (drop_valid && (drop_id == ID_W'(i))),
            .hit         (hit_vec[i]),
            .fail_due    (due_vec[i])
        );
    end

    xmon_resolve #(
        .NPROC (NPROC),
        .ID_W  (ID_W)
    ) u_resolve (
        .hit_vec   (hit_vec),
        .due_vec   (due_vec),
        .req_id    (req_id),
        .stex_live (stex_live),
        .grant     (grant)
    );

    // Register the exclusive-store answer for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stex_done <= 1'b0;
            stex_ok   <= 1'b0;
        end else begin
            stex_done <= stex_live;
            stex_ok   <= grant;
        end
    end

    // R4
    done_after_stex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stex_done |-> $past(req_valid && req_op == 2'b11));

    // R4
    ok_within_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stex_ok |-> stex_done);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !stex_done);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!stex_done && !stex_ok));
endmodule

// File: tb/excl_monitor_global_bench.sv
module excl_monitor_global_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  NP         = 4;
    localparam int  PERIOD     = 5;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [1:0]  req_id = 2'b00;
    logic [31:0] req_addr = '0;
    logic        drop_valid = 1'b0;
    logic [1:0]  drop_id = 2'b00;
    logic        stex_done;
    logic        stex_ok;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // Behavioural reference state.
    bit held [NP];
    int regn [NP];
    int cnt  [NP];

    always #(CLK_PERIOD / 2) clk = ~clk;

    excl_monitor_global u_excl_monitor_global (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_id     (req_id),
        .req_addr   (req_addr),
        .drop_valid (drop_valid),
        .drop_id    (drop_id),
        .stex_done  (stex_done),
        .stex_ok    (stex_ok)
    );

    task automatic check(input bit got_d, input bit got_o, input bit exp_d,
                         input bit exp_o, input string rq);
        total++;
        if (got_d !== exp_d || got_o !== exp_o) begin
            bad++;
            $display("FAIL %s: done/ok actual=%0b/%0b expected=%0b/%0b",
                     rq, got_d, got_o, exp_d, exp_o);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, compare after.
    task automatic step(input bit v, input logic [1:0] op, input int id,
                        input logic [31:0] addr, input bit dv, input int did,
                        input string rq);
        bit exp_d;
        bit exp_o;
        int r;
        req_valid  = v;
        req_op     = op;
        req_id     = id[1:0];
        req_addr   = addr;
        drop_valid = dv;
        drop_id    = did[1:0];
        exp_d = v && (op == 2'b11);
        exp_o = 1'b0;
        r = int'(addr >> 11);
        if (v) begin
            if (op == 2'b01) begin
                held[id] = 1;
                regn[id] = r;
            end else if (op == 2'b10) begin
                for (int j = 0; j < NP; j++)
                    if (j != id && held[j] && regn[j] == r) held[j] = 0;
            end else if (op == 2'b11) begin
                if (held[id] && regn[id] == r) begin
                    if (cnt[id] == PERIOD) cnt[id] = 0;
                    else begin
                        cnt[id]++;
                        exp_o = 1'b1;
                    end
                end
                held[id] = 0;
                if (exp_o)
                    for (int j = 0; j < NP; j++)
                        if (j != id && held[j] && regn[j] == r) held[j] = 0;
            end
        end
        if (dv) begin
            held[did] = 0;
            cnt[did]  = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check(stex_done, stex_ok, exp_d, exp_o, rq);
    endtask

    task automatic ldex(input int id, input logic [31:0] a, input string rq);
        step(1, 2'b01, id, a, 0, 0, rq);
    endtask
    task automatic stex(input int id, input logic [31:0] a, input string rq);
        step(1, 2'b11, id, a, 0, 0, rq);
    endtask
    task automatic store(input int id, input logic [31:0] a, input string rq);
        step(1, 2'b10, id, a, 0, 0, rq);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) begin
            held[i] = 0; regn[i] = 0; cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        check(stex_done, stex_ok, 0, 0, "R1 reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        check(stex_done, stex_ok, 0, 0, "R1 after release");
        stex(0, 32'h1000, "R1 slots open after reset");

        // Region matching and basic pairing.
        ldex(0, 32'h1000, "R3");
        stex(0, 32'h17FC, "R2 R4 same region granted");
        stex(0, 32'h1000, "R5 second stex denied");
        ldex(0, 32'h1000, "R3");
        stex(0, 32'h1800, "R2 next region denied");
        ldex(0, 32'h1000, "R3");
        ldex(0, 32'h2000, "R3 replace region");
        stex(0, 32'h1000, "R3 old region denied");

        // Foreign and own plain stores.
        ldex(1, 32'h2000, "R3");
        ldex(2, 32'h2010, "R3");
        store(3, 32'h2444, "R6 foreign store");
        stex(1, 32'h2000, "R6 p1 killed");
        stex(2, 32'h2000, "R6 p2 killed");
        ldex(1, 32'h3000, "R3");
        store(1, 32'h3000, "R6 own store");
        stex(1, 32'h3000, "R6 own store spares slot");

        // Grant spreads the kill, deny does not.
        ldex(0, 32'h4000, "R3");
        ldex(1, 32'h4100, "R3");
        stex(0, 32'h4000, "R7 p0 granted");
        stex(1, 32'h4000, "R7 p1 killed by grant");
        ldex(2, 32'h5000, "R3");
        ldex(3, 32'h5000, "R3");
        stex(2, 32'h6000, "R7 p2 denied mismatch");
        stex(3, 32'h5000, "R7 p3 survives deny");

        // Forced-failure period on a fresh counter.
        step(0, 2'b00, 0, 0, 1, 3, "R9 drop p3");
        for (int k = 0; k < 13; k++) begin
            ldex(3, 32'h7000, "R8");
            stex(3, 32'h7000, "R8 period");
            if (k == 2) stex(3, 32'h7000, "R8 open stex not counted");
        end

        // Drop behaviour.
        ldex(2, 32'h8000, "R3");
        step(0, 2'b00, 0, 0, 1, 2, "R9 drop p2");
        stex(2, 32'h8000, "R9 dropped denied");
        step(1, 2'b01, 1, 32'h8000, 1, 1, "R9 drop beats ldex");
        stex(1, 32'h8000, "R9 drop won");

        // Idle and plain loads have no effect.
        ldex(0, 32'h9000, "R3");
        step(0, 2'b11, 0, 32'h9000, 0, 0, "R10 invalid stex");
        step(0, 2'b10, 1, 32'h9000, 0, 0, "R10 invalid store");
        step(1, 2'b00, 1, 32'h9000, 0, 0, "R10 plain load");
        stex(0, 32'h9000, "R10 reservation intact");

        // Random mix against the model.
        for (int k = 0; k < 600; k++) begin
            logic [31:0] pool [4] = '{32'h1000, 32'h1400, 32'h2000, 32'hA000};
            int rv = $urandom;
            step(((rv & 7) != 0), 2'($urandom), int'($urandom % NP),
                 pool[$urandom % 4] + 32'($urandom % 64),
                 (($urandom % 16) == 0), int'($urandom % NP), "R4 R7 R8 random");
        end

        req_valid  = 1'b0;
        drop_valid = 1'b0;
        finished   = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule